// File: doc/BRIEF.md
# Static Memory Chip-Select Controller

This block sits between a processor and an external asynchronous memory bus for ROM, SRAM and flash parts. It splits the 32-bit address space into 256 MB regions using the top four address bits. Each region it serves drives one active-low chip select. The number of regions served is set by a parameter, which may be 4, 5 or 6.

Each region has its own settings: bus width (8, 16 or 32 bits), a wait count for the first access, a second wait count for later accesses, a page-mode enable and an enable bit. The processor sends one 32-bit word request. The request is held until a one-cycle acknowledge. The controller breaks the word into one, two or four external accesses, lowest address first. On reads it gathers the returned lanes into a word, and on writes it sends the word out one lane group at a time. A request to a region that is not served, or that is disabled, touches no pin and is acknowledged with an error flag.

After reset every region is enabled, set to 8 bits wide and set to the slowest timing, so an 8-bit boot device in region 0 works without setup.

Top module: `static_mem_ctl`

## Requirements
- R1: After reset, every served region is enabled, 8 bits wide, has both wait counts at 15 and has page mode off. While idle, all chip selects, the output enable and the write enable are high and no acknowledge is given.
- R2: A request with address bits [31:28] equal to k, where k is below NUM_SEG and region k is enabled, drives extCsN[k] low and leaves every other chip select high for the whole transfer. Address bits [1:0] are ignored (word access). extAddr bits [27:2] equal request bits [27:2] on every strobed cycle.
- R3: Width code 0 selects 8 bits and gives four external accesses. Code 1 selects 16 bits and gives two. Codes 2 and 3 select 32 bits and give one. Accesses go in rising byte-address order (extAddr[1:0] = 0,1,2,3 or 0,2), and narrow data uses extDataOut/extDataIn bits [7:0] or [15:0].
- R4: A read acknowledges with ackRdata holding the byte from external byte address A+i in bits [8i+7:8i], where A is the word address.
- R5: A write gives exactly one falling edge of extWeN for each external access. Each carries the matching request bytes on the low lanes, and output enable is never low at the same time as write enable.
- R6: With page mode off, each access holds its strobe low for first-wait + 1 cycles, with one strobe-high cycle between accesses. The acknowledge appears N(wf+1)+(N-1) cycles after the accept edge.
- R7: With page mode on, a read keeps output enable low across accesses. Accesses after the first last page-wait + 1 cycles each, with no gap.
- R8: With page mode on, a write uses page-wait + 1 cycles for accesses after the first, with one write-enable-high cycle before each of them.
- R9: A request with address bits [31:28] at or above NUM_SEG, or to a disabled region, drives no chip select or strobe. It is acknowledged with ackErr high in the cycle after the accept edge.
- R10: ackValid is high for exactly one cycle for each request.
- R11: A pulse on cfgWr with cfgSel = k writes region k's settings as cfgData = {enable, pageEn, pageWait[3:0], firstWait[3:0], width[1:0]}. The new settings apply to later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Settings write strobe |
| cfgSel | input | 4 | Region number to write |
| cfgData | input | 12 | Packed region settings |
| reqValid | input | 1 | Request held until acknowledge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the word |
| reqWdata | input | 32 | Write word |
| ackValid | output | 1 | One-cycle acknowledge |
| ackErr | output | 1 | Request hit no served, enabled region |
| ackRdata | output | 32 | Assembled read word |
| extAddr | output | 28 | External byte address |
| extDataOut | output | 32 | External write data |
| extDataIn | input | 32 | External read data |
| extDataOe | output | 1 | Write data drive enable |
| extCsN | output | 6 | Active-low chip selects |
| extOeN | output | 1 | Active-low output enable |
| extWeN | output | 1 | Active-low write enable |

## Verification
Every result in this block is tied to the acknowledge. The acknowledge comes a fixed number of edges after the accept edge. That number is 0 edges for a rejected request. Otherwise it is first-wait + 1 for one access, plus for each later access its own wait + 1, plus one gap cycle unless it is a page read. The bench computes this count from the settings it wrote. It counts rising edges from the request until it sees ackValid at a falling edge, and expects exactly count + 1. Data, error flag, strobe-low cycle counts and write-pulse counts are read at that falling edge, one cycle later for the pulse-end check, when no strobe is active.

// File: rtl/static_mem_pkg.sv
package static_mem_pkg;
  localparam int WAIT_W = 4;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef struct packed {
    logic              en;
    logic              pageEn;
    logic [WAIT_W-1:0] waitPage;
    logic [WAIT_W-1:0] waitFirst;
    logic [1:0]        width;   // 0: 8 bit, 1: 16 bit, 2/3: 32 bit
  } segCfg_t;

  localparam int CFG_W = $bits(segCfg_t);

  typedef struct packed {
    logic       load;
    logic       capture;
    logic [1:0] beat;
  } dpStrobe_t;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_GAP, S_DONE} busState_t;
endpackage

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import static_mem_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int REG_W   = 4
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic [REG_W-1:0]   cfgSel,
  input  segCfg_t            cfgData,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [REG_W-1:0]   reqRegion,
  output dpStrobe_t          strobe,
  output logic [1:0]         curWidth,
  output logic [NUM_SEG-1:0] extCsN,
  output logic               extOeN,
  output logic               extWeN,
  output logic               extDataOe,
  output logic               ackValid,
  output logic               ackErr
);
  segCfg_t           cfgRegs [NUM_SEG];
  segCfg_t           selCfg, cur;
  logic              hit;
  busState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic [1:0]        beat, lastBeat;
  logic [REG_W-1:0]  segIdx;
  logic              isWrite, errFlag;

  // settings registers, boot-safe reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SEG; i++) begin
      if (!rstN) begin
        cfgRegs[i] <= '{en: 1'b1, pageEn: 1'b0, waitPage: '1, waitFirst: '1, width: 2'd0};
      end else if (cfgWr && cfgSel == REG_W'(i)) begin
        cfgRegs[i] <= cfgData;
      end
    end
  end

  // region decode
  always_comb begin
    hit    = 1'b0;
    selCfg = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (reqRegion == REG_W'(i)) begin
        hit    = cfgRegs[i].en;
        selCfg = cfgRegs[i];
      end
    end
  end

  always_comb begin
    case (cur.width)
      2'd0:    lastBeat = 2'd3;
      2'd1:    lastBeat = 2'd1;
      default: lastBeat = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      beat    <= '0;
      cur     <= '0;
      segIdx  <= '0;
      isWrite <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          isWrite <= reqWrite;
          beat    <= '0;
          if (hit) begin
            cur     <= selCfg;
            segIdx  <= reqRegion;
            waitCnt <= selCfg.waitFirst;
            errFlag <= 1'b0;
            state   <= S_ACC;
          end else begin
            errFlag <= 1'b1;
            state   <= S_DONE;
          end
        end
        S_ACC: begin
          if (waitCnt != '0) begin
            waitCnt <= waitCnt - WAIT_W'(1);
          end else if (beat == lastBeat) begin
            state <= S_DONE;
          end else begin
            beat    <= beat + 2'd1;
            waitCnt <= cur.pageEn ? cur.waitPage : cur.waitFirst;
            state   <= (cur.pageEn && !isWrite) ? S_ACC : S_GAP;
          end
        end
        S_GAP:   state <= S_ACC;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign strobe.load    = (state == S_IDLE) && reqValid;
  assign strobe.capture = (state == S_ACC) && (waitCnt == '0) && !isWrite;
  assign strobe.beat    = beat;
  assign curWidth       = cur.width;

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_cs
    assign extCsN[k] = !(((state == S_ACC) || (state == S_GAP)) && (segIdx == REG_W'(k)));
  end

  assign extOeN    = !((state == S_ACC) && !isWrite);
  assign extWeN    = !((state == S_ACC) && isWrite);
  assign extDataOe = (state == S_ACC) && isWrite;
  assign ackValid  = (state == S_DONE);
  assign ackErr    = (state == S_DONE) && errFlag;
endmodule

// File: rtl/smc_dpath.sv
module smc_dpath
  import static_mem_pkg::*;
#(
  parameter int EXT_W = 28
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        width,
  input  logic [EXT_W-3:0]  reqWord,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] extDataIn,
  output logic [EXT_W-1:0]  extAddr,
  output logic [DATA_W-1:0] extDataOut,
  output logic [DATA_W-1:0] ackRdata
);
  logic [EXT_W-3:0]  baseWord;
  logic [DATA_W-1:0] wdataQ;
  logic [1:0]        lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseWord <= '0;
      wdataQ   <= '0;
    end else if (strobe.load) begin
      baseWord <= reqWord;
      wdataQ   <= reqWdata;
    end
  end

  always_comb begin
    case (width)
      2'd0: begin
        lowBits    = strobe.beat;
        extDataOut = {24'b0, wdataQ[{strobe.beat, 3'b000} +: 8]};
      end
      2'd1: begin
        lowBits    = {strobe.beat[0], 1'b0};
        extDataOut = {16'b0, wdataQ[{strobe.beat[0], 4'b0000} +: 16]};
      end
      default: begin
        lowBits    = 2'd0;
        extDataOut = wdataQ;
      end
    endcase
  end

  assign extAddr = {baseWord, lowBits};

  // per-lane read assembly
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic       laneHit;
    logic [7:0] laneSrc, laneQ;

    always_comb begin
      case (width)
        2'd0: begin
          laneHit = (strobe.beat == 2'(j));
          laneSrc = extDataIn[7:0];
        end
        2'd1: begin
          laneHit = (strobe.beat[0] == 1'(j / 2));
          laneSrc = extDataIn[(j % 2) * 8 +: 8];
        end
        default: begin
          laneHit = 1'b1;
          laneSrc = extDataIn[j * 8 +: 8];
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobe.load) laneQ <= '0;
      else if (strobe.capture && laneHit) laneQ <= laneSrc;
    end

    assign ackRdata[j * 8 +: 8] = laneQ;
  end
endmodule

// File: rtl/static_mem_ctl.sv
module static_mem_ctl
  import static_mem_pkg::*;
#(
  parameter int NUM_SEG    = 6,
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 28
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWr,
  input  logic [ADDR_W-REGION_LSB-1:0] cfgSel,
  input  logic [CFG_W-1:0]             cfgData,
  input  logic                         reqValid,
  input  logic                         reqWrite,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [DATA_W-1:0]            reqWdata,
  output logic                         ackValid,
  output logic                         ackErr,
  output logic [DATA_W-1:0]            ackRdata,
  output logic [REGION_LSB-1:0]        extAddr,
  output logic [DATA_W-1:0]            extDataOut,
  input  logic [DATA_W-1:0]            extDataIn,
  output logic                         extDataOe,
  output logic [NUM_SEG-1:0]           extCsN,
  output logic                         extOeN,
  output logic                         extWeN
);
  localparam int REG_W = ADDR_W - REGION_LSB;

  dpStrobe_t  strobe;
  logic [1:0] curWidth;
  logic       unusedAlign;

  assign unusedAlign = ^reqAddr[1:0];

  smc_ctrl #(.NUM_SEG(NUM_SEG), .REG_W(REG_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWr     (cfgWr),
    .cfgSel    (cfgSel),
    .cfgData   (segCfg_t'(cfgData)),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqRegion (reqAddr[ADDR_W-1:REGION_LSB]),
    .strobe    (strobe),
    .curWidth  (curWidth),
    .extCsN    (extCsN),
    .extOeN    (extOeN),
    .extWeN    (extWeN),
    .extDataOe (extDataOe),
    .ackValid  (ackValid),
    .ackErr    (ackErr)
  );

  smc_dpath #(.EXT_W(REGION_LSB)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .width      (curWidth),
    .reqWord    (reqAddr[REGION_LSB-1:2]),
    .reqWdata   (reqWdata),
    .extDataIn  (extDataIn),
    .extAddr    (extAddr),
    .extDataOut (extDataOut),
    .ackRdata   (ackRdata)
  );
endmodule

// File: rtl/static_mem_chk.sv
module static_mem_chk #(
  parameter int NUM_SEG = 6
)(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SEG-1:0] extCsN,
  input logic               extOeN,
  input logic               extWeN,
  input logic               ackValid,
  input logic               ackErr
);
  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~extCsN));

  // R2
  strobe_has_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!extOeN || !extWeN) |-> !(&extCsN));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!extOeN && !extWeN));

  // R7
  oe_run_same_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!extOeN && $past(!extOeN)) |-> $stable(extCsN));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackErr |-> (ackValid && (&extCsN) && extOeN && extWeN));

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);
endmodule

bind static_mem_ctl static_mem_chk #(.NUM_SEG(NUM_SEG)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .extCsN   (extCsN),
  .extOeN   (extOeN),
  .extWeN   (extWeN),
  .ackValid (ackValid),
  .ackErr   (ackErr)
);

// File: tb/static_mem_ctl_test.sv
module static_mem_ctl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic [3:0]  cfgSel = '0;
  logic [11:0] cfgData = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic        ackValid, ackErr, extDataOe, extOeN, extWeN;
  logic [31:0] ackRdata, extDataOut, extDataIn;
  logic [27:0] extAddr;
  logic [5:0]  extCsN;

  int total = 0, bad = 0;
  int csBadTot = 0, addrBadTot = 0, oeLowTot = 0, wrBeatTot = 0;
  logic        weNPrev = 1'b1;
  logic [5:0]  expCs = '1;
  logic [25:0] expWord = '0;
  logic [1:0]  monWidth = '0;
  logic [31:0] shadow = '0;

  always #5 clk = ~clk;

  static_mem_ctl uut (.*);

  function automatic logic [7:0] pat(input logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // external memory model: four bytes from the presented address upward
  assign extDataIn = {pat(extAddr + 28'd3), pat(extAddr + 28'd2), pat(extAddr + 28'd1), pat(extAddr)};

  function automatic logic [31:0] expRead(input logic [27:0] off);
    logic [27:0] a = {off[27:2], 2'b00};
    return {pat(a + 28'd3), pat(a + 28'd2), pat(a + 28'd1), pat(a)};
  endfunction

  function automatic int beatsOf(input logic [1:0] w);
    return (w == 2'd0) ? 4 : (w == 2'd1) ? 2 : 1;
  endfunction

  function automatic int expLat(input logic [1:0] w, input logic [3:0] wf, input logic [3:0] wp,
                                input logic pg, input logic wr);
    int n = beatsOf(w);
    int later = pg ? int'(wp) : int'(wf);
    int gap = (!pg || wr) ? 1 : 0;
    return (int'(wf) + 1) + (n - 1) * (later + 1 + gap);
  endfunction

  function automatic int expOeLow(input logic [1:0] w, input logic [3:0] wf, input logic [3:0] wp,
                                  input logic pg);
    int n = beatsOf(w);
    int later = pg ? int'(wp) : int'(wf);
    return (int'(wf) + 1) + (n - 1) * (later + 1);
  endfunction

  // pin monitor, cumulative counters
  always @(negedge clk) begin
    if (extCsN != 6'h3F && extCsN != expCs) csBadTot++;
    if ((!extOeN || !extWeN) && extAddr[27:2] != expWord) addrBadTot++;
    if (!extOeN) oeLowTot++;
    if (!extWeN && weNPrev) begin
      wrBeatTot++;
      case (monWidth)
        2'd0:    shadow[{extAddr[1:0], 3'b000} +: 8] = extDataOut[7:0];
        2'd1:    shadow[{extAddr[1], 4'b0000} +: 16] = extDataOut[15:0];
        default: shadow = extDataOut;
      endcase
    end
    weNPrev = extWeN;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgSet(input logic [3:0] sel, input logic en, input logic pg,
                        input logic [3:0] wp, input logic [3:0] wf, input logic [1:0] w);
    @(negedge clk);
    cfgWr = 1'b1; cfgSel = sel; cfgData = {en, pg, wp, wf, w};
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic doReq(input logic [3:0] region, input logic [27:0] off, input logic wr,
                       input logic [31:0] wd, input logic [1:0] w, input logic expErr,
                       output int cyc, output logic err, output logic [31:0] rd, output logic dropped);
    bit seen = 0;
    @(negedge clk);
    expCs = expErr ? 6'h3F : ~(6'd1 << region);
    expWord = off[27:2];
    monWidth = w;
    reqValid = 1'b1; reqWrite = wr; reqAddr = {region, off}; reqWdata = wd;
    cyc = 0;
    while (!seen && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (ackValid) seen = 1;
    end
    err = ackErr; rd = ackRdata;
    reqValid = 1'b0;
    @(negedge clk);
    dropped = !ackValid;
  endtask

  typedef struct packed {
    logic [3:0]  seg;
    logic [1:0]  wd;
    logic [3:0]  wf;
    logic [3:0]  wp;
    logic        pg;
    logic        wr;
    logic [27:0] off;
    logic [31:0] wdata;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 2'd2, 4'd2, 4'd0, 1'b0, 1'b0, 28'h0000100, 32'h0},
    '{4'd2, 2'd1, 4'd1, 4'd0, 1'b0, 1'b0, 28'h0ABCDE4, 32'h0},
    '{4'd3, 2'd0, 4'd0, 4'd0, 1'b0, 1'b0, 28'h123456B, 32'h0},
    '{4'd4, 2'd0, 4'd3, 4'd1, 1'b1, 1'b0, 28'h0000FF0, 32'h0},
    '{4'd5, 2'd1, 4'd2, 4'd0, 1'b1, 1'b0, 28'h7654320, 32'h0},
    '{4'd1, 2'd2, 4'd1, 4'd0, 1'b0, 1'b1, 28'h0000040, 32'hDEADBEEF},
    '{4'd2, 2'd1, 4'd0, 4'd0, 1'b0, 1'b1, 28'h0002000, 32'hA1B2C3D4},
    '{4'd3, 2'd0, 4'd2, 4'd0, 1'b0, 1'b1, 28'h00000FC, 32'h01234567},
    '{4'd4, 2'd0, 4'd2, 4'd1, 1'b1, 1'b1, 28'h0FFFFFC, 32'h89ABCDEF},
    '{4'd0, 2'd3, 4'd0, 4'd0, 1'b0, 1'b0, 28'hFFFFFFC, 32'h0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, oe0, wb0, cs0, ad0;
    logic err, dropped;
    logic [31:0] rd;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 idle pins after reset
    chk(extCsN == 6'h3F && extOeN && extWeN && !ackValid, "R1 idle pins",
        {extCsN, extOeN, extWeN, ackValid}, {6'h3F, 1'b1, 1'b1, 1'b0});

    // R1 default settings: 8 bit, waits 15, no page
    oe0 = oeLowTot;
    doReq(4'd0, 28'h0000040, 1'b0, 32'h0, 2'd0, 1'b0, cyc, err, rd, dropped);
    chk(cyc == expLat(2'd0, 4'd15, 4'd15, 1'b0, 1'b0) + 1, "R1 default latency", cyc, 68);
    chk(rd == expRead(28'h0000040) && !err, "R1 R4 default read", rd, expRead(28'h0000040));
    chk(oeLowTot - oe0 == 64, "R1 R6 default strobe cycles", oeLowTot - oe0, 64);

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      string tag = v.pg ? (v.wr ? "R8" : "R7") : "R6";
      cfgSet(v.seg, 1'b1, v.pg, v.wp, v.wf, v.wd);
      oe0 = oeLowTot; wb0 = wrBeatTot; cs0 = csBadTot; ad0 = addrBadTot;
      doReq(v.seg, v.off, v.wr, v.wdata, v.wd, 1'b0, cyc, err, rd, dropped);
      chk(cyc == expLat(v.wd, v.wf, v.wp, v.pg, v.wr) + 1, {tag, " latency"}, cyc,
          expLat(v.wd, v.wf, v.wp, v.pg, v.wr) + 1);
      chk(!err && dropped, "R10 ack single, no error", {err, dropped}, 2'b01);
      chk(csBadTot == cs0 && addrBadTot == ad0, "R2 chip select and address",
          {csBadTot - cs0, addrBadTot - ad0}, 0);
      if (v.wr) begin
        chk(wrBeatTot - wb0 == beatsOf(v.wd), "R3 R5 write pulse count", wrBeatTot - wb0, beatsOf(v.wd));
        chk(shadow == v.wdata, "R5 write lanes", shadow, v.wdata);
        chk(oeLowTot == oe0, "R5 no output enable on write", oeLowTot - oe0, 0);
      end else begin
        chk(rd == expRead(v.off), "R3 R4 read assembly", rd, expRead(v.off));
        chk(oeLowTot - oe0 == expOeLow(v.wd, v.wf, v.wp, v.pg), {tag, " strobe cycles"},
            oeLowTot - oe0, expOeLow(v.wd, v.wf, v.wp, v.pg));
      end
    end

    // R9 region beyond served count
    oe0 = oeLowTot; cs0 = csBadTot;
    doReq(4'd6, 28'h0000010, 1'b0, 32'h0, 2'd2, 1'b1, cyc, err, rd, dropped);
    chk(err && cyc == 1, "R9 unserved region", {err, 8'(cyc)}, {1'b1, 8'd1});
    chk(oeLowTot == oe0 && csBadTot == cs0, "R9 no pins on unserved", oeLowTot - oe0, 0);
    doReq(4'd15, 28'h0000010, 1'b1, 32'h55, 2'd2, 1'b1, cyc, err, rd, dropped);
    chk(err && cyc == 1 && dropped, "R9 R10 top region write", {err, 8'(cyc)}, {1'b1, 8'd1});

    // R11 disable a region, then re-enable
    cfgSet(4'd2, 1'b0, 1'b0, 4'd0, 4'd0, 2'd2);
    cs0 = csBadTot;
    doReq(4'd2, 28'h0000020, 1'b0, 32'h0, 2'd2, 1'b1, cyc, err, rd, dropped);
    chk(err && cyc == 1 && csBadTot == cs0, "R9 R11 disabled region", {err, 8'(cyc)}, {1'b1, 8'd1});
    cfgSet(4'd2, 1'b1, 1'b0, 4'd0, 4'd0, 2'd2);
    doReq(4'd2, 28'h0000020, 1'b0, 32'h0, 2'd2, 1'b0, cyc, err, rd, dropped);
    chk(!err && cyc == 2 && rd == expRead(28'h0000020), "R11 re-enabled region", rd, expRead(28'h0000020));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule